// File: doc/BRIEF.md
# Radix-2 Single-Path Delay-Feedback FFT Stage

This block is one stage of a streamed radix-2 decimation-in-frequency FFT or inverse FFT. It accepts one complex sample per clock, with 16-bit signed real and imaginary parts, whenever `valid_i` is high. A feedback delay line of N/2 entries holds the first half of each N-sample frame. While the second half arrives, each new sample x[n+N/2] is paired with the stored x[n]. The halved sum g[n] goes straight to the output. The halved difference is weighted by a twiddle factor and written back into the same delay line.

While the first half of the following frame enters, the weighted differences h[n] leave the delay line in order, so frames stream back to back with no gap. The stage has a built-in table of N/2 twiddle factors in Q2.14 format, computed when the design is elaborated. The `inv_i` input selects the forward transform or the conjugate twiddles of the inverse transform. Stages are cascaded by halving N. Output reordering and the 1/N inverse scaling belong outside the stage.

Top module: `sdf_fft_stage`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `re_o`/`im_o` are 0. After release, the frame position restarts at sample 0 and pending difference values are discarded.
- R2: The first N/2 samples accepted after reset produce no valid output.
- R3: Accepting frame sample N/2+n gives, one clock later, `valid_o`=1 and the output floor((x[n]+x[n+N/2])/2) on the real and imaginary parts separately.
- R4: With `inv_i`=0 (forward) when sample N/2+n is accepted, h[n] = d·W^n. Here d = floor((x[n]−x[n+N/2])/2) per part and W^n = C − jS, with C = round(16384·cos(2πn/N)) and S = round(16384·sin(2πn/N)). Each product part is rounded half-up after dividing by 16384.
- R5: With `inv_i`=1 (inverse), the conjugate twiddle C + jS is used in place of C − jS.
- R6: The h[n] values of a frame come out in order n = 0..N/2−1, one per accepted sample, while the next frame's first N/2 samples are accepted, each one clock after acceptance. Consecutive frames need no idle cycle.
- R7: A clock with `valid_i`=0 advances nothing. On the next clock `valid_o` is 0 and `re_o`/`im_o` keep their values.
- R8: A twiddle product part above 32767 or below −32768 saturates to that limit.
- R9: The twiddle at n = 0 is exactly 16384 + j0, so h[0] = d. At n = N/4 it is exactly −j16384 (forward) or +j16384 (inverse).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| inv_i | input | 1 | 0 forward FFT, 1 inverse (conjugate twiddles) |
| re_i | input | 16 | Input real part, signed |
| im_i | input | 16 | Input imaginary part, signed |
| valid_o | output | 1 | Output sample strobe |
| re_o | output | 16 | Output real part, signed |
| im_o | output | 16 | Output imaginary part, signed |

## Verification
The assertions assume that frame boundaries come only from counting accepted samples since reset, with no separate frame marker. They also assume that `inv_i` is stable while a frame's second half is accepted, because the mode is applied when the difference is weighted. The bench changes `inv_i` only between frames and keeps every frame a whole N samples. It drives inputs one time unit after the rising edge and inserts idle cycles only inside a frame, so both the gap behaviour and the contiguous-stream behaviour are exercised within those assumptions.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  localparam int DW  = 16;
  localparam int TWW = 16;

  typedef struct packed {
    logic signed [DW-1:0] re;
    logic signed [DW-1:0] im;
  } cplx_t;
endpackage

// File: rtl/sdf_twiddle_rom.sv
module sdf_twiddle_rom
  import sdf_pkg::*;
#(
  parameter int N    = 64,
  parameter int FRAC = 14,
  localparam int HALF = N / 2,
  localparam int AW   = $clog2(HALF)
) (
  input  logic [AW-1:0]           idx_i,
  output logic signed [TWW-1:0]   cos_o,
  output logic signed [TWW-1:0]   sin_o
);

  logic signed [TWW-1:0] cos_tab [HALF];
  logic signed [TWW-1:0] sin_tab [HALF];

  // table values fixed at elaboration, rounded half-up
  for (genvar i = 0; i < HALF; i++) begin : g_entry
    localparam real ANG   = 6.283185307179586 * real'(i) / real'(N);
    localparam int  COS_Q = $rtoi($floor($cos(ANG) * (2.0 ** FRAC) + 0.5));
    localparam int  SIN_Q = $rtoi($floor($sin(ANG) * (2.0 ** FRAC) + 0.5));
    assign cos_tab[i] = TWW'(COS_Q);
    assign sin_tab[i] = TWW'(SIN_Q);
  end

  assign cos_o = cos_tab[idx_i];
  assign sin_o = sin_tab[idx_i];

  always_comb begin
    if (idx_i == '0)
      AST_TW_ORIGIN: assert (cos_o == TWW'(1 << FRAC) && sin_o == '0); // R9
  end

endmodule

// File: rtl/sdf_delay_line.sv
module sdf_delay_line
  import sdf_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  cplx_t din_i,
  output cplx_t dout_o
);

  cplx_t taps [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
    end else if (push_i) begin
      taps[0] <= din_i;
      for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
    end
  end

  assign dout_o = taps[DEPTH-1];

  AST_FIFO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_i |=> $stable(dout_o)); // R7

endmodule

// File: rtl/sdf_bfly.sv
module sdf_bfly
  import sdf_pkg::*;
(
  input  cplx_t a_i,
  input  cplx_t b_i,
  output cplx_t sum_o,
  output cplx_t dif_o
);

  logic signed [DW:0] s_re, s_im, d_re, d_im;

  always_comb begin
    s_re = {a_i.re[DW-1], a_i.re} + {b_i.re[DW-1], b_i.re};
    s_im = {a_i.im[DW-1], a_i.im} + {b_i.im[DW-1], b_i.im};
    d_re = {a_i.re[DW-1], a_i.re} - {b_i.re[DW-1], b_i.re};
    d_im = {a_i.im[DW-1], a_i.im} - {b_i.im[DW-1], b_i.im};
  end

  // halve to keep the 16-bit range (floor)
  assign sum_o.re = s_re[DW:1];
  assign sum_o.im = s_im[DW:1];
  assign dif_o.re = d_re[DW:1];
  assign dif_o.im = d_im[DW:1];

endmodule

// File: rtl/sdf_cmul.sv
module sdf_cmul
  import sdf_pkg::*;
#(
  parameter int FRAC = 14
) (
  input  cplx_t                 d_i,
  input  logic signed [TWW-1:0] cos_i,
  input  logic signed [TWW-1:0] sin_i,
  input  logic                  inv_i,
  output cplx_t                 p_o
);

  localparam int PW = DW + TWW + 1;
  localparam logic signed [PW-1:0] MAXV = PW'((1 << (DW - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);
  localparam logic signed [PW-1:0] HALF_LSB = PW'(1) <<< (FRAC - 1);

  logic signed [PW-1:0] dre, dim, wre, wim;
  logic signed [PW-1:0] acc_re, acc_im;

  function automatic logic signed [DW-1:0] round_sat(input logic signed [PW-1:0] v);
    logic signed [PW-1:0] sh;
    sh = (v + HALF_LSB) >>> FRAC;
    if (sh > MAXV)      return MAXV[DW-1:0];
    else if (sh < MINV) return MINV[DW-1:0];
    else                return sh[DW-1:0];
  endfunction

  always_comb begin
    dre = PW'(d_i.re);
    dim = PW'(d_i.im);
    wre = PW'(cos_i);
    wim = inv_i ? PW'(sin_i) : -PW'(sin_i);
    acc_re = dre * wre - dim * wim;
    acc_im = dre * wim + dim * wre;
  end

  assign p_o.re = round_sat(acc_re);
  assign p_o.im = round_sat(acc_im);

endmodule

// File: rtl/sdf_fft_stage.sv
module sdf_fft_stage
  import sdf_pkg::*;
#(
  parameter int N    = 64,
  parameter int FRAC = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 inv_i,
  input  logic signed [DW-1:0] re_i,
  input  logic signed [DW-1:0] im_i,
  output logic                 valid_o,
  output logic signed [DW-1:0] re_o,
  output logic signed [DW-1:0] im_o
);

  localparam int HALF = N / 2;
  localparam int CW   = $clog2(N);
  localparam int AW   = CW - 1;

  logic [CW-1:0] pos_q;
  logic          primed_q;
  logic          upper;
  logic [AW-1:0] tw_idx;

  cplx_t x_in, fb_out, fb_in, g_val, d_val, h_val;
  logic signed [TWW-1:0] tw_cos, tw_sin;

  assign upper  = pos_q[CW-1];
  assign tw_idx = pos_q[AW-1:0];
  assign x_in.re = re_i;
  assign x_in.im = im_i;

  sdf_delay_line #(.DEPTH(HALF)) u_fb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (valid_i),
    .din_i  (fb_in),
    .dout_o (fb_out)
  );

  sdf_bfly u_bfly (
    .a_i   (fb_out),
    .b_i   (x_in),
    .sum_o (g_val),
    .dif_o (d_val)
  );

  sdf_twiddle_rom #(.N(N), .FRAC(FRAC)) u_rom (
    .idx_i (tw_idx),
    .cos_o (tw_cos),
    .sin_o (tw_sin)
  );

  sdf_cmul #(.FRAC(FRAC)) u_mul (
    .d_i   (d_val),
    .cos_i (tw_cos),
    .sin_i (tw_sin),
    .inv_i (inv_i),
    .p_o   (h_val)
  );

  // first half: store input; second half: feed weighted difference back
  assign fb_in = upper ? h_val : x_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      primed_q <= 1'b0;
    end else if (valid_i) begin
      pos_q <= pos_q + 1'b1;
      if (pos_q == CW'(N - 1)) primed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      re_o    <= '0;
      im_o    <= '0;
    end else if (valid_i) begin
      valid_o <= upper | primed_q;
      re_o    <= upper ? g_val.re : fb_out.re;
      im_o    <= upper ? g_val.im : fb_out.im;
    end else begin
      valid_o <= 1'b0;
    end
  end

  AST_PRIME_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !upper && !primed_q |=> !valid_o); // R2

  AST_UPPER_EMITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && upper |=> valid_o); // R3

  AST_DRAIN_EMITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !upper && primed_q |=> valid_o); // R6

  AST_VALID_NEEDS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(re_o) && $stable(im_o) && !valid_o); // R7

endmodule

// File: tb/sdf_fft_stage_tb_top.sv
module sdf_fft_stage_tb_top;
  localparam int N  = 64;
  localparam int H  = N / 2;
  localparam int QD = 2048;
  localparam int NT = 6;

  // inv, a_re, a_im, b_re, b_im, g_re, g_im, h_re, h_im  (a at n=0, b at n=N/2)
  localparam int TAB [NT][9] = '{
    '{0,    100,    -50,    20,    30,    60,   -10,     40,    -40},
    '{0,     -7,      3,     0,     0,    -4,     1,     -4,      1},
    '{0,  32767,  32767, 32767, 32767, 32767, 32767,      0,      0},
    '{0, -32768, -32768, 32767, 32767,    -1,    -1, -32768, -32768},
    '{0,      0,      0,     1,    -1,     0,    -1,     -1,      0},
    '{1,      5,      5,    -5,     9,     0,     7,      5,     -2}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic inv_i = 1'b0;
  logic signed [15:0] re_i = '0;
  logic signed [15:0] im_i = '0;
  logic valid_o;
  logic signed [15:0] re_o, im_o;

  always #4 clk = ~clk;

  sdf_fft_stage #(.N(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .inv_i(inv_i),
    .re_i(re_i), .im_i(im_i), .valid_o(valid_o), .re_o(re_o), .im_o(im_o)
  );

  int checks = 0;
  int fails  = 0;
  int exp_re [QD];
  int exp_im [QD];
  int exp_tol [QD];
  string exp_tag [QD];
  int wr_p = 0;
  int rd_p = 0;
  int fr_re [N];
  int fr_im [N];
  int acc;
  logic cap_v;
  int last_re = 0;
  int last_im = 0;
  bit done = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc   <= 0;
      cap_v <= 1'b0;
    end else begin
      cap_v <= valid_i;
      if (valid_i) acc <= acc + 1;
    end
  end

  function automatic int clamp16(real v);
    int r;
    r = $rtoi($floor(v + 0.5));
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic int absi(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic push(int r, int i, int tol, string tag);
    if (wr_p < QD) begin
      exp_re[wr_p] = r; exp_im[wr_p] = i; exp_tol[wr_p] = tol; exp_tag[wr_p] = tag;
      wr_p++;
    end
  endtask

  // model of one frame: sums first, then weighted differences
  task automatic queue_frame(int inv, int tol, string htag);
    for (int n = 0; n < H; n++)
      push((fr_re[n] + fr_re[n+H]) >>> 1, (fr_im[n] + fr_im[n+H]) >>> 1, 0, "R3");
    for (int n = 0; n < H; n++) begin
      int dr, di;
      real th, c, s, hr, hi;
      dr = (fr_re[n] - fr_re[n+H]) >>> 1;
      di = (fr_im[n] - fr_im[n+H]) >>> 1;
      th = 6.283185307179586 * n / N;
      c = $cos(th); s = $sin(th);
      if (inv != 0) begin
        hr = dr * c - di * s; hi = di * c + dr * s;
      end else begin
        hr = dr * c + di * s; hi = di * c - dr * s;
      end
      push(clamp16(hr), clamp16(hi), tol, htag);
    end
  endtask

  task automatic drive(int r, int i, int inv);
    @(posedge clk); #1;
    valid_i = 1'b1; re_i = 16'(r); im_i = 16'(i); inv_i = inv[0];
  endtask

  task automatic idle(int k);
    repeat (k) begin
      @(posedge clk); #1;
      valid_i = 1'b0;
    end
  endtask

  task automatic send_frame(int inv, int gap);
    for (int n = 0; n < N; n++) begin
      drive(fr_re[n], fr_im[n], inv);
      if (gap != 0 && (n % 5) == 2) idle(2);
    end
  endtask

  task automatic clear_frame();
    for (int n = 0; n < N; n++) begin fr_re[n] = 0; fr_im[n] = 0; end
  endtask

  task automatic rand_frame();
    for (int n = 0; n < N; n++) begin
      fr_re[n] = int'($urandom_range(65535)) - 32768;
      fr_im[n] = int'($urandom_range(65535)) - 32768;
    end
  endtask

  always @(negedge clk) begin
    int idx;
    bit ev;
    if (!rst_ni) begin
      last_re = 0; last_im = 0;
    end else if (!done) begin
      idx = acc - 1;
      ev = cap_v && (((idx % N) >= H) || (idx >= N));
      checks++;
      if (valid_o !== ev) begin
        fails++;
        $display("FAIL R2 R3 R6 valid_o at sample %0d: actual=%0b expected=%0b", idx, valid_o, ev);
      end
      if (!cap_v) begin
        checks++;
        if (valid_o !== 1'b0 || int'(re_o) != last_re || int'(im_o) != last_im) begin
          fails++;
          $display("FAIL R7 idle hold: actual=%0b/%0d/%0d expected=0/%0d/%0d",
                   valid_o, re_o, im_o, last_re, last_im);
        end
      end
      if (valid_o === 1'b1 && ev) begin
        checks++;
        if (rd_p >= wr_p) begin
          fails++;
          $display("FAIL R6 unexpected output: actual=%0d/%0d expected=none", re_o, im_o);
        end else begin
          if (absi(int'(re_o) - exp_re[rd_p]) > exp_tol[rd_p] ||
              absi(int'(im_o) - exp_im[rd_p]) > exp_tol[rd_p]) begin
            fails++;
            $display("FAIL %s output %0d: actual=%0d/%0d expected=%0d/%0d",
                     exp_tag[rd_p], rd_p, re_o, im_o, exp_re[rd_p], exp_im[rd_p]);
          end
          rd_p++;
        end
      end
      if (valid_o === 1'b1) begin
        last_re = int'(re_o); last_im = int'(im_o);
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R6 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || re_o !== '0 || im_o !== '0) begin
      fails++;
      $display("FAIL R1 reset outputs: actual=%0b/%0d/%0d expected=0/0/0", valid_o, re_o, im_o);
    end
    @(posedge clk); #1 rst_ni = 1'b1;

    // vector table: single butterfly at n=0 (R9 unit twiddle, R3 sum)
    for (int e = 0; e < NT; e++) begin
      clear_frame();
      fr_re[0] = TAB[e][1]; fr_im[0] = TAB[e][2];
      fr_re[H] = TAB[e][3]; fr_im[H] = TAB[e][4];
      push(TAB[e][5], TAB[e][6], 0, "R3");
      for (int n = 1; n < H; n++) push(0, 0, 0, "R3");
      push(TAB[e][7], TAB[e][8], 0, (TAB[e][0] != 0) ? "R5 R9" : "R4 R9");
      for (int n = 1; n < H; n++) push(0, 0, 0, "R6");
      send_frame(TAB[e][0], 0);
    end

    // random forward and inverse frames, streamed back to back
    for (int f = 0; f < 3; f++) begin
      rand_frame(); queue_frame(0, 2, "R4 R6"); send_frame(0, 0);
    end
    for (int f = 0; f < 2; f++) begin
      rand_frame(); queue_frame(1, 2, "R5 R6"); send_frame(1, 0);
    end

    // R9: quarter-turn twiddle, exact in both modes
    clear_frame(); fr_re[N/4] = 1000;
    queue_frame(0, 0, "R9"); send_frame(0, 0);
    queue_frame(1, 0, "R9"); send_frame(1, 0);

    // R8: saturating product at n=N/8 (expect 32767 + j0)
    clear_frame();
    fr_re[N/8] = 32767; fr_im[N/8] = 32767;
    fr_re[N/8+H] = -32768; fr_im[N/8+H] = -32768;
    queue_frame(0, 0, "R8"); send_frame(0, 0);

    // R7: idle cycles inside a frame
    rand_frame(); queue_frame(0, 2, "R4 R7"); send_frame(0, 1);

    // flush: zero frame drains the previous differences
    clear_frame(); queue_frame(0, 0, "R6"); send_frame(0, 0);
    idle(6);
    checks++; // R6: exactly the last frame's differences stay pending
    if (wr_p - rd_p != H) begin
      fails++;
      $display("FAIL R6 pending outputs: actual=%0d expected=%0d", wr_p - rd_p, H);
    end

    // R1: reset mid-stream, then restart with priming (R2)
    @(posedge clk); #1 rst_ni = 1'b0; valid_i = 1'b0;
    wr_p = 0; rd_p = 0;
    @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || re_o !== '0 || im_o !== '0) begin
      fails++;
      $display("FAIL R1 mid reset outputs: actual=%0b/%0d/%0d expected=0/0/0", valid_o, re_o, im_o);
    end
    @(posedge clk); #1 rst_ni = 1'b1;
    rand_frame(); queue_frame(1, 2, "R1 R5"); send_frame(1, 0);
    clear_frame(); queue_frame(0, 0, "R1 R6"); send_frame(0, 0);
    idle(6);
    checks++;
    if (wr_p - rd_p != H) begin
      fails++;
      $display("FAIL R1 restart pending: actual=%0d expected=%0d", wr_p - rd_p, H);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule